// File: doc/BRIEF.md
# Low-Power Escape Lane Transmitter

This block drives the positive and negative single-ended lines of the first data lane of a display link while the lane is in its low-power regime. It carries configuration and command bytes to a display panel, typically during panel bring-up, by opening an escape, announcing a low-power data transfer, streaming the bytes and closing the escape again. No clock lane is involved: every bit is encoded in the order of line states, so the receiver recovers timing from the transitions alone.

On the host side, bytes arrive over a valid/ready handshake. A flag on the final byte closes the burst. On the lane side, the block presents the P and N logic levels and a drive-enable for the pad drivers. The line pair has four states, written LP-PN with P first: LP-00, LP-01, LP-10 and LP-11. Each state is held for a programmable number of system clock cycles. The hold value is captured when a burst starts.

Top module: `lpesc_tx`

## Requirements
- R1: While reset is asserted, lp_oe is 0 and the lines are LP-11. From the first clock after reset release, lp_oe is 1. The idle (control) state drives LP-11 with in_ready low for as long as in_valid stays low.
- R2: A burst starts when in_valid is seen high in idle. The lines then step through LP-10, LP-00, LP-01, LP-00.
- R3: After that entry sequence, the transfer-entry code 0xE1 is sent most significant bit first. Each bit is a mark state followed by a space state LP-00. The mark is LP-10 (P=1, N=0) for a 1 and LP-01 for a 0.
- R4: Payload bytes follow the code, least significant bit first, in the same mark/space form. The first byte is taken at the end of the code.
- R5: in_ready is high only at a byte boundary. A byte transfers when in_valid and in_ready are both high. If no byte is offered at a boundary, the lane holds LP-00 until one is offered.
- R6: After the byte marked with in_last, the lane drives LP-10 and then LP-11 and returns to idle. It stays at LP-11 until a new burst opens with a fresh entry sequence.
- R7: Every state inside a burst, apart from a stretched space, lasts exactly H cycles. H is cfg_hold sampled when the burst starts; cfg_hold = 0 selects the default of 5 cycles (50 ns at 100 MHz).
- R8: Changing cfg_hold during a burst has no effect on that burst's state durations.
- R9: The lines leave LP-11 only towards LP-10. A mark state is always followed by LP-00, except the closing LP-10, which goes to LP-11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 8 | Cycles per line state; 0 selects the default |
| in_data | input | 8 | Byte offered by the host |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | Offered byte ends the burst |
| in_ready | output | 1 | Block takes the byte on this cycle if valid |
| lp_p | output | 1 | Positive line logic level |
| lp_n | output | 1 | Negative line logic level |
| lp_oe | output | 1 | Line driver enable |

## Verification
On every cycle, the assertions check the legal successor of each line state, the minimum run length of each state against the captured hold value, the timer's bound, and that in_ready appears only at byte boundaries. They cannot show that the right bits go out in the right order, that durations are exact rather than merely long enough, that a mid-burst change of cfg_hold is ignored, or that the default hold applies. The bench's scenarios show these by decoding the lane into runs of states and comparing them with a sequence computed from the byte values, including a sweep over all 256 byte values.

// File: rtl/lpesc_pkg.sv
package lpesc_pkg;
  localparam int BYTE_W       = 8;
  localparam int SYM_PER_BYTE = 2 * BYTE_W;

  // line state codes, P in bit 1, N in bit 0
  localparam logic [1:0] LS_00 = 2'b00;
  localparam logic [1:0] LS_01 = 2'b01;
  localparam logic [1:0] LS_10 = 2'b10;
  localparam logic [1:0] LS_11 = 2'b11;

  localparam logic [BYTE_W-1:0] XFER_CODE = 8'hE1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ENTRY, PH_CMD, PH_DATA, PH_WAIT, PH_EXIT
  } phase_t;

  // mark/space coding of one bit
  function automatic logic [1:0] bit_sym(input logic b, input logic space);
    if (space) return LS_00;
    return b ? LS_10 : LS_01;
  endfunction

  // escape entry steps after leaving LP-11
  function automatic logic [1:0] entry_sym(input logic [1:0] k);
    case (k)
      2'd0:    return LS_10;
      2'd1:    return LS_00;
      2'd2:    return LS_01;
      default: return LS_00;
    endcase
  endfunction

  function automatic logic [7:0] hold_pick(input logic [7:0] cfg, input logic [7:0] dflt);
    return (cfg == 8'd0) ? dflt : cfg;
  endfunction
endpackage

// File: rtl/lpesc_hold_timer.sv
module lpesc_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [HOLD_W-1:0] hold,
  output logic              tick
);
  logic [HOLD_W-1:0] cnt;

  assign tick = !restart && (cnt == hold - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R7: the counter never runs past the hold value
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < hold);
endmodule

// File: rtl/lpesc_sym_enc.sv
module lpesc_sym_enc
  import lpesc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data,
  output logic [1:0]        sym
);
  localparam int POS_W = IDX_W - 1;
  logic [POS_W-1:0] pos;
  assign pos = idx[IDX_W-1:1];

  always_comb begin
    case (phase)
      PH_ENTRY: sym = entry_sym(idx[1:0]);
      PH_CMD:   sym = bit_sym(XFER_CODE[POS_W'(BYTE_W-1) - pos], idx[0]); // MSB first
      PH_DATA:  sym = bit_sym(data[pos], idx[0]);                         // LSB first
      PH_WAIT:  sym = LS_00;
      PH_EXIT:  sym = (idx == '0) ? LS_10 : LS_11;
      default:  sym = LS_11;
    endcase
  end
endmodule

// File: rtl/lpesc_tx.sv
module lpesc_tx
  import lpesc_pkg::*;
#(
  parameter int          HOLD_W   = 8,
  parameter logic [7:0]  HOLD_DEF = 8'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              lp_p,
  output logic              lp_n,
  output logic              lp_oe
);
  localparam int              IDX_W    = $clog2(SYM_PER_BYTE);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_PER_BYTE - 1);

  phase_t             phase;
  logic [IDX_W-1:0]   idx;
  logic [BYTE_W-1:0]  shreg;
  logic               last_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               oe_q;
  logic               tick;
  logic               take;
  logic               byte_end;
  logic [1:0]         lane_sym;

  assign byte_end = tick && (idx == LAST_IDX);
  assign in_ready = (phase == PH_WAIT) ||
                    (phase == PH_CMD  && byte_end) ||
                    (phase == PH_DATA && byte_end && !last_q);
  assign take     = in_valid && in_ready;

  lpesc_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase == PH_IDLE || phase == PH_WAIT),
    .hold    (hold_q),
    .tick    (tick)
  );

  lpesc_sym_enc #(.IDX_W(IDX_W)) u_enc (
    .phase (phase),
    .idx   (idx),
    .data  (shreg),
    .sym   (lane_sym)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      shreg  <= '0;
      last_q <= 1'b0;
      hold_q <= HOLD_W'(HOLD_DEF);
      oe_q   <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (take) begin
        shreg  <= in_data;
        last_q <= in_last;
      end
      case (phase)
        PH_IDLE: if (in_valid) begin
          phase  <= PH_ENTRY;
          idx    <= '0;
          hold_q <= HOLD_W'(hold_pick(8'(cfg_hold), HOLD_DEF));
        end
        PH_ENTRY: if (tick) begin
          if (idx == IDX_W'(3)) begin phase <= PH_CMD; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_CMD: if (tick) begin
          if (byte_end) begin phase <= take ? PH_DATA : PH_WAIT; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_DATA: if (tick) begin
          if (byte_end) begin
            idx <= '0;
            if (last_q)    phase <= PH_EXIT;
            else if (take) phase <= PH_DATA;
            else           phase <= PH_WAIT;
          end else idx <= idx + 1'b1;
        end
        PH_WAIT: if (take) begin phase <= PH_DATA; idx <= '0; end
        PH_EXIT: if (tick) begin
          if (idx == IDX_W'(1)) begin phase <= PH_IDLE; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign lp_p  = lane_sym[1];
  assign lp_n  = lane_sym[0];
  assign lp_oe = oe_q;

  // run-length bookkeeping for the assertions
  logic [1:0]        sym_q;
  logic [HOLD_W:0]   run_len;
  logic              sym_chg;
  assign sym_chg = (lane_sym != sym_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q   <= LS_11;
      run_len <= '0;
    end else begin
      sym_q <= lane_sym;
      if (sym_chg)        run_len <= (HOLD_W+1)'(1);
      else if (!(&run_len)) run_len <= run_len + 1'b1;
    end
  end

  // R9: leaving LP-11 goes to LP-10 only
  p_idle_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == LS_11 && sym_chg) |-> lane_sym == LS_10);

  // R9: a mark is followed by a space, or the closing LP-10 by LP-11
  p_mark_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sym_q == LS_10 || sym_q == LS_01) && sym_chg) |->
      (lane_sym == LS_00 || (sym_q == LS_10 && lane_sym == LS_11)));

  // R7: no state inside a burst is shorter than the captured hold
  p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_chg && phase != PH_IDLE && $past(phase) != PH_IDLE) |->
      run_len >= {1'b0, hold_q});

  // R5: ready only at a byte boundary
  p_ready_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (phase == PH_CMD || phase == PH_DATA || phase == PH_WAIT));

  // R6: the final byte's last space is followed by the closing LP-10
  p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && byte_end && last_q) |=> (lane_sym == LS_10));
endmodule

// File: tb/sim_lpesc_tx.sv
module sim_lpesc_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_hold = 8'd1;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready, lp_p, lp_n, lp_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  lpesc_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .lp_p(lp_p), .lp_n(lp_n), .lp_oe(lp_oe)
  );

  // lane run-length recorder
  logic [1:0] run_st [0:1023];
  int         run_len[0:1023];
  int         nrun = 0;
  logic [1:0] prev_st = 2'b11;
  int         cur_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({lp_p, lp_n} == prev_st) cur_len++;
      else begin
        run_st[nrun % 1024]  = prev_st;
        run_len[nrun % 1024] = cur_len;
        nrun++;
        prev_st = {lp_p, lp_n};
        cur_len = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected symbol k of a burst with bytes b[]
  function automatic logic [1:0] exp_sym(input int k, input logic [7:0] b[4]);
    logic [1:0] ent[4] = '{2'b10, 2'b00, 2'b01, 2'b00};
    int j;
    logic bt;
    if (k < 4) return ent[k];
    j = k - 4;
    if (j < 16) begin
      if (j % 2 == 1) return 2'b00;
      bt = (8'hE1 >> (7 - j / 2)) & 1'b1;
      return bt ? 2'b10 : 2'b01;
    end
    j = j - 16;
    if (j % 2 == 1) return 2'b00;
    bt = (b[j / 16] >> ((j % 16) / 2)) & 1'b1;
    return bt ? 2'b10 : 2'b01;
  endfunction

  task automatic burst(input int n, input logic [7:0] b[4], input int hld,
                       input int gap, input int new_hold, input string req);
    int base, need, hexp;
    hexp = (hld == 0) ? 5 : hld;
    @(negedge clk);
    base = nrun;
    cfg_hold = 8'(hld);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      in_data = b[i];
      in_last = (i == n - 1);
      if (i > 0 && gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (i == 0 && new_hold >= 0) cfg_hold = 8'(new_hold);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    need = 22 + 16 * n;
    while (nrun < base + need) @(negedge clk);
    for (int k = 0; k < need - 2; k++) begin
      int r = (base + 1 + k) % 1024;
      logic [1:0] e = exp_sym(k, b);
      check(run_st[r] == e, req, int'(run_st[r]), int'(e));
      if (gap > 0) check(run_len[r] >= hexp, "R5 stretched run", run_len[r], hexp);
      else         check(run_len[r] == hexp, "R7 hold", run_len[r], hexp);
    end
    begin
      int r = (base + need - 1) % 1024;
      check(run_st[r] == 2'b10, "R6 closing mark", int'(run_st[r]), 2);
      check(run_len[r] == hexp, "R6 closing hold", run_len[r], hexp);
    end
  endtask

  initial begin
    logic [7:0] b[4];
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lp_oe == 1'b0, "R1 oe in reset", int'(lp_oe), 0);
    check({lp_p, lp_n} == 2'b11, "R1 lines in reset", int'({lp_p, lp_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(lp_oe == 1'b1, "R1 oe after reset", int'(lp_oe), 1);
    repeat (20) @(negedge clk);
    check({lp_p, lp_n} == 2'b11, "R1 idle lines", int'({lp_p, lp_n}), 3);
    check(in_ready == 1'b0, "R1 idle ready", int'(in_ready), 0);

    // R2 R3 R4: single byte, hold 1
    b = '{8'hA5, 8'h00, 8'h00, 8'h00};
    burst(1, b, 1, 0, -1, "R2 R3 R4 one byte");
    repeat (3) @(negedge clk);
    check({lp_p, lp_n} == 2'b11, "R6 back to idle", int'({lp_p, lp_n}), 3);
    check(in_ready == 1'b0, "R6 idle ready", int'(in_ready), 0);

    // R4 R7: three bytes, hold 2
    b = '{8'h00, 8'hFF, 8'h3C, 8'h00};
    burst(3, b, 2, 0, -1, "R4 three bytes");
    // R7: default hold
    b = '{8'h81, 8'h7E, 8'h00, 8'h00};
    burst(2, b, 0, 0, -1, "R7 default hold");
    // R5: host gap longer than a byte time
    b = '{8'h12, 8'h34, 8'h00, 8'h00};
    burst(2, b, 3, 60, -1, "R5 gap");
    // R8: cfg_hold changed mid burst
    b = '{8'h55, 8'hAA, 8'h00, 8'h00};
    burst(2, b, 2, 0, 6, "R8 hold change ignored");
    // R2 R4 R6: sweep over every byte value, back-to-back bursts
    for (int v = 0; v < 256; v++) begin
      b = '{8'(v), 8'h00, 8'h00, 8'h00};
      burst(1, b, 1, 0, -1, "R4 sweep");
    end
    repeat (4) @(negedge clk);
    check({lp_p, lp_n} == 2'b11, "R6 final idle", int'({lp_p, lp_n}), 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule